// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs single register accesses from a host to an Ethernet PHY over the two-wire MII management interface. The host presents an operation (read or write), a 5-bit PHY address, a 5-bit register address and, for a write, 16 bits of payload. The block then produces the management clock and either drives the shared data line or releases it, one bit at a time, until the frame is complete.

Every frame starts with a 32-bit run of ones. A write then sends one unbroken 32-bit command word. A read sends a 14-bit header, releases the line and shifts in 18 bits: two turnaround bits followed by the 16-bit register value. A present PHY pulls the second turnaround bit low, so a high level in that slot marks the read as failed. At the end of the frame a one-cycle done pulse returns the read value and the error flag. The management clock is the system clock divided by a parameter, with a 50% duty cycle. While a frame is in progress, busy is high and new requests are ignored.

Top module: `mdio_master`

## Requirements
- R1: While reset is asserted and after it is released, mdc, mdio_oe, busy and done are 0, mdio_o is 1, rd_data is 0 and rd_err is 0.
- R2: Frame bits 0 to 31 are all 1 with mdio_oe high, for reads and for writes.
- R3: For a read, frame bits 32 to 45 carry, MSB first, start `01`, opcode `10`, req_phy[4:0] and req_reg[4:0`]`, with mdio_oe high.
- R4: For a read, mdio_oe is low for frame bits 46 to 63 and mdio_o rests at 1. At done, rd_data holds frame bits 48 to 63 as sampled on mdio_i, MSB first. rd_data changes only in a done cycle.
- R5: At the done of a read, rd_err equals the level sampled on mdio_i in frame bit 47 (the second turnaround bit). At the done of a write, rd_err is 0.
- R6: For a write, frame bits 32 to 63 carry, MSB first, `01`, opcode `01`, req_phy, req_reg, turnaround `10` and req_wdata[15:0], with mdio_oe high for the whole frame.
- R7: Each frame bit lasts 2*DIV_HALF clocks. mdc is low for the first DIV_HALF clocks of a bit and high for the next DIV_HALF. mdio_o and mdio_oe change only while mdc is low. mdio_i is sampled at the clock edge that raises mdc.
- R8: A request is taken on a clock edge where req_valid is 1 and busy is 0. busy is high from that edge for 128*DIV_HALF clocks. done is then high for exactly one cycle, with busy low. req_valid has no effect while busy is high.
- R9: Whenever busy is low, mdc and mdio_oe are 0 and mdio_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write payload |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Value returned by the last read |
| rd_err | output | 1 | Last read found no PHY response |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data level driven on the line |
| mdio_oe | output | 1 | Drive enable for the data line |
| mdio_i | input | 1 | Level observed on the data line |

## Verification
Counting from the accepting edge, frame bit k raises mdc 2*DIV_HALF*k + DIV_HALF clocks later and lowers it at 2*DIV_HALF*(k+1). busy drops and done rises exactly 128*DIV_HALF clocks after acceptance. The bench's timeline model counts clocks from the edge where it saw the request taken and derives the expected mdc, drive enable, data bit, busy and done for every cycle from that count alone. All outputs are sampled on the falling system clock edge. The PHY model changes its reply on the falling edge of mdc, so a sample taken in the wrong cycle reads the wrong bit and rd_data or rd_err come out wrong at the done cycle.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int HDR_END    = 46;  // first released bit of a read
  localparam int RX_BITS    = FRAME_BITS - HDR_END;
  localparam int IDX_W      = $clog2(FRAME_BITS);

  typedef enum logic {
    MST_IDLE = 1'b0,
    MST_RUN  = 1'b1
  } mst_state_e;

  // assembles preamble plus command word, MSB is sent first
  function automatic logic [FRAME_BITS-1:0] build_frame(
    input logic        wr,
    input logic [4:0]  phy,
    input logic [4:0]  regad,
    input logic [15:0] wdata
  );
    logic [31:0] cmd;
    if (wr) cmd = {2'b01, 2'b01, phy, regad, 2'b10, wdata};
    else    cmd = {2'b01, 2'b10, phy, regad, 18'h00000};
    return {{PRE_BITS{1'b1}}, cmd};
  endfunction

endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int DIV_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic rise_en,
  output logic fall_en
);
  localparam int PERIOD = 2 * DIV_HALF;
  localparam int CW     = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] RISE_AT = CW'(DIV_HALF - 1);
  localparam logic [CW-1:0] FALL_AT = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)                cnt_d = '0;
    else if (cnt_q == FALL_AT) cnt_d = '0;
    else                     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign rise_en = run && (cnt_q == RISE_AT);
  assign fall_en = run && (cnt_q == FALL_AT);
endmodule

// File: rtl/mdio_tx_path.sv
module mdio_tx_path
  import mdio_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [FRAME_BITS-1:0] frame,
  input  logic                  load_read,
  input  logic                  fall_en,
  output logic                  tx_bit,
  output logic                  drive_now,
  output logic                  drive_next,
  output logic                  last_bit
);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] REL_IDX   = IDX_W'(HDR_END);
  localparam logic [IDX_W-1:0] PRE_REL   = IDX_W'(HDR_END - 1);

  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [IDX_W-1:0]      idx_q, idx_d;
  logic                  rd_q, rd_d;

  always_comb begin
    sh_d  = sh_q;
    idx_d = idx_q;
    rd_d  = rd_q;
    if (load) begin
      sh_d  = frame;
      idx_d = '0;
      rd_d  = load_read;
    end else if (fall_en) begin
      sh_d  = {sh_q[FRAME_BITS-2:0], 1'b1};
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '1;
      idx_q <= '0;
      rd_q  <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      idx_q <= idx_d;
      rd_q  <= rd_d;
    end
  end

  assign tx_bit     = sh_q[FRAME_BITS-1];
  assign drive_now  = !rd_q || (idx_q < REL_IDX);
  assign drive_next = !rd_q || (idx_q < PRE_REL);
  assign last_bit   = (idx_q == LAST_IDX);
endmodule

// File: rtl/mdio_rx_path.sv
module mdio_rx_path
  import mdio_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               sample_en,
  input  logic               mdio_i,
  output logic [RX_BITS-1:0] rx_word
);
  logic [RX_BITS-1:0] rx_q, rx_d;

  always_comb begin
    rx_d = rx_q;
    if (clear)          rx_d = '0;
    else if (sample_en) rx_d = {rx_q[RX_BITS-2:0], mdio_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_q <= '0;
    else        rx_q <= rx_d;
  end

  assign rx_word = rx_q;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [4:0]  req_phy,
  input  logic [4:0]  req_reg,
  input  logic [15:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] rd_data,
  output logic        rd_err,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  mst_state_e          st_q, st_d;
  logic                mdc_q, mdc_d;
  logic                oe_q, oe_d;
  logic                done_q, done_d;
  logic [15:0]         rdat_q, rdat_d;
  logic                rerr_q, rerr_d;
  logic                rd_op_q, rd_op_d;

  logic                run, rise_en, fall_en, accept;
  logic                tx_bit, drive_now, drive_next, last_bit;
  logic [RX_BITS-1:0]  rx_word;
  logic [FRAME_BITS-1:0] frame;

  assign run    = (st_q == MST_RUN);
  assign accept = (st_q == MST_IDLE) && req_valid;
  assign frame  = build_frame(req_write, req_phy, req_reg, req_wdata);

  mdio_clkdiv #(.DIV_HALF(DIV_HALF)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .rise_en (rise_en),
    .fall_en (fall_en)
  );

  mdio_tx_path u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .frame      (frame),
    .load_read  (!req_write),
    .fall_en    (fall_en),
    .tx_bit     (tx_bit),
    .drive_now  (drive_now),
    .drive_next (drive_next),
    .last_bit   (last_bit)
  );

  mdio_rx_path u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (accept),
    .sample_en (rise_en && !drive_now),
    .mdio_i    (mdio_i),
    .rx_word   (rx_word)
  );

  always_comb begin
    st_d    = st_q;
    mdc_d   = mdc_q;
    oe_d    = oe_q;
    done_d  = 1'b0;
    rdat_d  = rdat_q;
    rerr_d  = rerr_q;
    rd_op_d = rd_op_q;
    unique case (st_q)
      MST_IDLE: begin
        if (req_valid) begin
          st_d    = MST_RUN;
          oe_d    = 1'b1;
          mdc_d   = 1'b0;
          rd_op_d = !req_write;
        end
      end
      MST_RUN: begin
        if (rise_en) mdc_d = 1'b1;
        if (fall_en) begin
          mdc_d = 1'b0;
          if (last_bit) begin
            st_d   = MST_IDLE;
            oe_d   = 1'b0;
            done_d = 1'b1;
            if (rd_op_q) begin
              rdat_d = rx_word[15:0];
              rerr_d = rx_word[16];
            end else begin
              rerr_d = 1'b0;
            end
          end else begin
            oe_d = drive_next;
          end
        end
      end
      default: st_d = MST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= MST_IDLE;
      mdc_q   <= 1'b0;
      oe_q    <= 1'b0;
      done_q  <= 1'b0;
      rdat_q  <= '0;
      rerr_q  <= 1'b0;
      rd_op_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      mdc_q   <= mdc_d;
      oe_q    <= oe_d;
      done_q  <= done_d;
      rdat_q  <= rdat_d;
      rerr_q  <= rerr_d;
      rd_op_q <= rd_op_d;
    end
  end

  assign busy    = run;
  assign done    = done_q;
  assign rd_data = rdat_q;
  assign rd_err  = rerr_q;
  assign mdc     = mdc_q;
  assign mdio_oe = oe_q;
  assign mdio_o  = oe_q ? tx_bit : 1'b1;
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic [15:0] rd_data,
  input logic        rd_err,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);
  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe && mdio_o)); // R9

  AST_STABLE_MDC_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R7

  AST_MDC_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> busy); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_DONE_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R8

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(rd_data) && $stable(rd_err))); // R4
endmodule

bind mdio_master mdio_master_chk i_mdio_master_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .done    (done),
  .rd_data (rd_data),
  .rd_err  (rd_err),
  .mdc     (mdc),
  .mdio_o  (mdio_o),
  .mdio_oe (mdio_oe)
);

// File: tb/test_mdio_master.sv
`timescale 1ns/1ps
module test_mdio_master;
  localparam int H      = 2;
  localparam int FRAMEC = 128 * H;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [4:0]  req_phy, req_reg;
  logic [15:0] req_wdata;
  logic        busy, done, rd_err, mdc, mdio_o, mdio_oe, mdio_i;
  logic [15:0] rd_data;

  int n_vec = 0;
  int n_bad = 0;
  int cyc   = 0;

  // PHY model state
  logic        phy_present;
  logic [15:0] phy_data;
  logic        phy_drive = 1'b1;
  int          phy_cnt   = 0;

  // timeline model
  logic        m_act = 1'b0;
  int          m_t   = 0;
  logic        m_wr  = 1'b0;
  logic [63:0] m_frame = '1;
  logic        m_present = 1'b1;
  logic [15:0] m_pdata = '0;
  logic        chk_on = 1'b0;

  always #4 clk = ~clk;

  mdio_master #(.DIV_HALF(H)) i_mdio_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rd_data(rd_data), .rd_err(rd_err),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  assign mdio_i = mdio_oe ? mdio_o : phy_drive;

  always @(posedge mdc) phy_cnt = (phy_cnt + 1) % 64;

  always @(negedge mdc) begin
    logic [17:0] resp;
    resp = phy_present ? {2'b10, phy_data} : 18'h3FFFF;
    if (phy_cnt >= 46) phy_drive = resp[63 - phy_cnt];
    else               phy_drive = 1'b1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0d actual=%h expected=%h", tag, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_act = 1'b0;
    end else if (m_act && m_t < FRAMEC) begin
      m_t++;
    end else begin
      m_act = 1'b0;
      if (req_valid) begin
        m_act     = 1'b1;
        m_t       = 0;
        m_wr      = req_write;
        m_present = phy_present;
        m_pdata   = phy_data;
        m_frame   = {32'hFFFF_FFFF, 2'b01, req_write ? 2'b01 : 2'b10, req_phy, req_reg,
                     req_write ? {2'b10, req_wdata} : 18'h0};
      end
    end
    if (cyc == 150000) begin
      n_bad++;
      $display("FAIL R8 watchdog expired actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (chk_on && rst_n) begin
      logic busy_e, done_e, mdc_e, oe_e, mdo_e;
      int   bitn;
      string tg;
      busy_e = m_act && (m_t < FRAMEC);
      done_e = m_act && (m_t == FRAMEC);
      bitn   = m_t / (2 * H);
      mdc_e  = 1'b0; oe_e = 1'b0; mdo_e = 1'b1;
      if (busy_e) begin
        mdc_e = (m_t % (2 * H)) >= H;
        oe_e  = m_wr || (bitn < 46);
        mdo_e = oe_e ? m_frame[63 - bitn] : 1'b1;
      end
      if (!busy_e)        tg = "R9";
      else if (bitn < 32) tg = "R2";
      else if (m_wr)      tg = "R6";
      else if (bitn < 46) tg = "R3";
      else                tg = "R4";
      chk("R8 busy", {31'b0, busy}, {31'b0, busy_e});
      chk("R8 done", {31'b0, done}, {31'b0, done_e});
      chk("R7 mdc",  {31'b0, mdc},  {31'b0, mdc_e});
      chk({tg, " oe"},     {31'b0, mdio_oe}, {31'b0, oe_e});
      chk({tg, " mdio_o"}, {31'b0, mdio_o},  {31'b0, mdo_e});
      if (done_e) begin
        if (m_wr) chk("R5 write err", {31'b0, rd_err}, 32'd0);
        else begin
          chk("R5 read err", {31'b0, rd_err}, {31'b0, !m_present});
          if (m_present) chk("R4 read data", {16'b0, rd_data}, {16'b0, m_pdata});
        end
      end
    end
  end

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  task automatic issue(input logic w, input logic [4:0] p, input logic [4:0] r,
                       input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_phy = p; req_reg = r; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done();
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_phy = '0; req_reg = '0; req_wdata = '0;
    phy_present = 1'b1; phy_data = 16'h1234;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 mdc",  {31'b0, mdc},     32'd0);
    chk("R1 oe",   {31'b0, mdio_oe}, 32'd0);
    chk("R1 mdio", {31'b0, mdio_o},  32'd1);
    chk("R1 busy", {31'b0, busy},    32'd0);
    chk("R1 done", {31'b0, done},    32'd0);
    chk("R1 data", {16'b0, rd_data}, 32'd0);
    chk("R1 err",  {31'b0, rd_err},  32'd0);
    rst_n = 1'b1;
    chk_on = 1'b1;
    repeat (4) @(negedge clk);

    // R6 write frame
    issue(1'b1, 5'h01, 5'h02, 16'hA5C3);
    // R3/R4 read, PHY present
    phy_data = 16'h1234;
    issue(1'b0, 5'h1F, 5'h00, 16'h0000);
    phy_data = 16'h8001;
    issue(1'b0, 5'h0A, 5'h15, 16'hFFFF);

    // R8 request while busy is ignored
    phy_data = 16'hBEEF;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_phy = 5'h03; req_reg = 5'h04;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (50) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_phy = 5'h1C; req_reg = 5'h1B; req_wdata = 16'h0F0F;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done();
    repeat (3) @(negedge clk);
    chk("R8 idle after ignored req", {31'b0, busy}, 32'd0);

    // R5 absent PHY
    phy_present = 1'b0;
    issue(1'b0, 5'h07, 5'h01, 16'h0000);
    phy_present = 1'b1;

    // R8 back-to-back: request held across done
    phy_data = 16'h5A5A;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_phy = 5'h11; req_reg = 5'h0E; req_wdata = 16'h3C96;
    wait_done();
    @(negedge clk);
    req_valid = 1'b0;
    wait_done();
    repeat (10) @(negedge clk);
    chk("R9 final idle mdc", {31'b0, mdc}, 32'd0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule